// File: doc/BRIEF.md
# Programmable Buzzer Tone Generator

This block drives a pair of buzzer pins with a square-wave tone. A 3-bit pitch code sets the length of one tone period and a 4-bit loudness code sets the fraction of that period spent at the active level. All timing is counted in pulses of a 32.768 kHz tick enable that arrives alongside the system clock. The active time is the full period times the duty, rounded, and it always starts at the beginning of the period.

Software controls the block through one 16-bit control word. The word can be written whole or one byte at a time, and it is read back at any time. It holds a polarity bit, the loudness field, the pitch field and a 2-bit run field. At the highest pitch the period is only eight ticks long, so loudness there has eighth-step resolution and codes pair up. At every other pitch it has sixteenth-step resolution. New pitch and loudness values wait for the current period to finish. Polarity changes act at once.

Top module: `tone_buzzer`

## Requirements
- R1: After reset the control word reads 0x0000, and both `out_p` and `out_n` are 0.
- R2: Control word layout: bit 12 is polarity, bits 11:8 are loudness, bits 6:4 are pitch, and bits 1:0 are the run field. Bits 15:13, 7, 3 and 2 always read 0, and writes to them are ignored.
- R3: `wr_be[0]` enables a write to bits 7:0 and `wr_be[1]` enables a write to bits 15:8. A byte whose enable is 0 keeps its old value.
- R4: Pitch code 0 gives a period of 8 ticks. Pitch code c from 1 to 7 gives a period of 16·c ticks: 16, 32, 48, 64, 80, 96 and 112.
- R5: For pitch codes 1 to 7, loudness code d gives d/16 of the period at the active level. Code 0 is treated like code 1.
- R6: For pitch code 0, the active time is max(1, d>>1) ticks out of 8. Codes 0 to 3 give 1 tick, codes 4 and 5 give 2 ticks, and so on, up to codes 14 and 15, which give 7 ticks.
- R7: Each period starts at the active level, stays there for its whole active time, and spends the rest of the period at the inactive level.
- R8: A change to pitch or loudness made while running does not alter the current period. It takes effect from the next period.
- R9: While running, `out_n` is always the complement of `out_p`.
- R10: With polarity 0 the active level of `out_p` is 1. With polarity 1 both pins are inverted, and the inversion takes effect at once.
- R11: With run field 00 the generator is idle: its count restarts from zero, and both pins sit at the inactive level (0 with polarity 0, 1 with polarity 1). A nonzero run field makes the tone run continuously. The first period begins two clock cycles after the write that starts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse at 32.768 kHz that advances the tone counter |
| wr_en | input | 1 | Write strobe for the control word |
| wr_be | input | 2 | Byte enables: bit 0 for the low byte, bit 1 for the high byte |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current value of the control word |
| out_p | output | 1 | Tone output |
| out_n | output | 1 | Complementary tone output |

## Verification
Some properties are checked on every cycle by the assertions. While running, the count stays below the captured period, and the captured active time lies between one tick and one tick less than the period. The captured settings change only when a period wraps or while idle. Two more hold at all times: the pins are complementary while running and sit at the polarity level while idle, and reserved bits always read zero. Other behaviours only the bench scenarios can show: the exact period and active time for each pitch and loudness code, the pairing of loudness codes at the top pitch, byte-lane merging, and a mid-period write leaving the rest of the current period untouched.

// File: rtl/tone_pkg.sv
package tone_pkg;
    localparam int FREQ_W  = 3;
    localparam int DUTY_W  = 4;
    localparam int MODE_W  = 2;
    localparam int CNT_W   = 7;
    localparam int TOP_PER = 8;   // ticks per period at pitch code 0
    localparam int STEP    = 16;  // ticks per pitch step for codes 1..7
    localparam logic [15:0] CTRL_MASK = 16'h1F73;

    typedef struct packed {
        logic              pol;
        logic [DUTY_W-1:0] duty;
        logic [FREQ_W-1:0] freq;
        logic [MODE_W-1:0] mode;
    } ctrl_t;

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] hi;
    } gen_st_t;
endpackage

// File: rtl/tone_ctrl_reg.sv
module tone_ctrl_reg
    import tone_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_be,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output ctrl_t       ctrl
);
    localparam int LANES = 2;

    logic [15:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (wr_en) begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_be[l]) word_d[l*8 +: 8] = wr_data[l*8 +: 8];
            end
        end
        word_d = word_d & CTRL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign rd_data = word_q;
    assign ctrl = '{pol: word_q[12], duty: word_q[11:8], freq: word_q[6:4], mode: word_q[1:0]};

    // R2: reserved bits never read as 1
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~CTRL_MASK) == 16'h0);
    // R3: a lane without enable keeps its value
    a_r3_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_be[1]) |=> $stable(rd_data[15:8]));
endmodule

// File: rtl/tone_timing_map.sv
module tone_timing_map
    import tone_pkg::*;
(
    input  logic [FREQ_W-1:0] freq,
    input  logic [DUTY_W-1:0] duty,
    output logic [CNT_W-1:0]  per,
    output logic [CNT_W-1:0]  hi
);
    localparam int EIGHTH = TOP_PER / 8;
    localparam int SIXTEENTH_UNIT = STEP / 16;

    logic [DUTY_W-2:0] eighths;
    logic [DUTY_W-1:0] sixteenths;

    always_comb begin
        eighths    = (duty[DUTY_W-1:1] == '0) ? (DUTY_W-1)'(1) : duty[DUTY_W-1:1];
        sixteenths = (duty == '0) ? DUTY_W'(1) : duty;
        if (freq == '0) begin
            per = CNT_W'(TOP_PER);
            hi  = CNT_W'(eighths) * CNT_W'(EIGHTH);
        end else begin
            per = CNT_W'(freq) * CNT_W'(STEP);
            hi  = CNT_W'(sixteenths) * CNT_W'(freq) * CNT_W'(SIXTEENTH_UNIT);
        end
    end
endmodule

// File: rtl/tone_wave_gen.sv
module tone_wave_gen
    import tone_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run_req,
    input  logic [CNT_W-1:0] per_in,
    input  logic [CNT_W-1:0] hi_in,
    output logic             active,
    output logic             tone
);
    gen_st_t st_d, st_q;
    logic    wrap;

    assign wrap = tick && (st_q.cnt == st_q.per - CNT_W'(1));

    always_comb begin
        st_d     = st_q;
        st_d.run = run_req;
        if (!st_q.run) begin
            st_d.cnt = '0;
            st_d.per = per_in;
            st_d.hi  = hi_in;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.per = per_in;
            st_d.hi  = hi_in;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        if (!run_req) st_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{run: 1'b0, cnt: '0, per: CNT_W'(TOP_PER), hi: CNT_W'(1)};
        else        st_q <= st_d;
    end

    assign active = st_q.run;
    assign tone   = st_q.run && (st_q.cnt < st_q.hi);

    // R4: count stays inside the captured period
    a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> st_q.cnt < st_q.per);
    // R7: active time is nonempty and shorter than the period
    a_r7_hi_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.hi != '0) && (st_q.hi < st_q.per));
    // R8: captured settings hold until a period boundary
    a_r8_hold_to_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !wrap) |=> $stable(st_q.per) && $stable(st_q.hi));
    // R11: idle keeps the count at zero
    a_r11_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run |-> st_q.cnt == '0);
endmodule

// File: rtl/tone_buzzer.sv
module tone_buzzer
    import tone_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        wr_en,
    input  logic [1:0]  wr_be,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        out_p,
    output logic        out_n
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] per_w, hi_w;
    logic             active, tone;

    tone_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .rd_data(rd_data), .ctrl(ctrl)
    );

    tone_timing_map u_map (
        .freq(ctrl.freq), .duty(ctrl.duty), .per(per_w), .hi(hi_w)
    );

    tone_wave_gen u_gen (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run_req(ctrl.mode != '0),
        .per_in(per_w), .hi_in(hi_w), .active(active), .tone(tone)
    );

    assign out_p = tone ^ ctrl.pol;
    assign out_n = (active && !tone) ^ ctrl.pol;

    // R9: complementary pins while running
    a_r9_complement: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> out_p != out_n);
    // R11 / R10: idle pins rest at the polarity level
    a_r11_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (out_p == rd_data[12]) && (out_n == rd_data[12]));
endmodule

// File: tb/tone_buzzer_bench.sv
module tone_buzzer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] rd_data;
    logic        out_p, out_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tone_buzzer u_tone_buzzer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .rd_data(rd_data), .out_p(out_p), .out_n(out_n)
    );

    // {freq, duty, expected active ticks, expected period}
    localparam int NV = 14;
    localparam logic [3:0][7:0] VEC [NV] = '{
        '{8'd0, 8'd0,  8'd1,   8'd8},
        '{8'd0, 8'd3,  8'd1,   8'd8},
        '{8'd0, 8'd4,  8'd2,   8'd8},
        '{8'd0, 8'd5,  8'd2,   8'd8},
        '{8'd0, 8'd15, 8'd7,   8'd8},
        '{8'd1, 8'd0,  8'd1,   8'd16},
        '{8'd1, 8'd1,  8'd1,   8'd16},
        '{8'd2, 8'd5,  8'd10,  8'd32},
        '{8'd3, 8'd8,  8'd24,  8'd48},
        '{8'd4, 8'd15, 8'd60,  8'd64},
        '{8'd5, 8'd9,  8'd45,  8'd80},
        '{8'd6, 8'd12, 8'd72,  8'd96},
        '{8'd7, 8'd15, 8'd105, 8'd112},
        '{8'd7, 8'd1,  8'd7,   8'd112}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 2'b00;
    endtask

    task automatic pulse;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    // samples a window of n ticks, counts mismatches against active-then-inactive shape
    task automatic measure(input int hi, input int per, input int n, output int bad, output int highs, output int cbad);
        bad = 0; highs = 0; cbad = 0;
        for (int i = 0; i < n; i++) begin
            if (i < per && out_p) highs++;
            if (out_p != ((i % per) < hi)) bad++;
            if (out_n == out_p) cbad++;
            pulse();
        end
    endtask

    initial begin
        int bad, highs, cbad;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rd_data == 16'h0, "R1 reset word", rd_data, 0);
        check(out_p == 1'b0 && out_n == 1'b0, "R1 reset pins", {out_p, out_n}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reserved bits
        wr(2'b11, 16'hFFFF);
        check(rd_data == 16'h1F73, "R2 reserved mask", rd_data, 16'h1F73);
        wr(2'b11, 16'h0000);
        // R3 byte lanes
        wr(2'b10, 16'hFFFF);
        check(rd_data == 16'h1F00, "R3 high lane only", rd_data, 16'h1F00);
        wr(2'b01, 16'h0055);
        check(rd_data == 16'h1F51, "R3 low lane only", rd_data, 16'h1F51);
        wr(2'b11, 16'h0000);
        @(negedge clk);
        check(out_p == 1'b0 && out_n == 1'b0, "R11 idle pins pol0", {out_p, out_n}, 0);

        // R4 R5 R6 R7 R9 vector table
        for (int v = 0; v < NV; v++) begin
            int f, d, h, p;
            f = VEC[v][3]; d = VEC[v][2]; h = VEC[v][1]; p = VEC[v][0];
            wr(2'b11, 16'h0000);
            @(negedge clk);
            wr(2'b11, 16'((d << 8) | (f << 4) | 1));
            @(negedge clk);
            measure(h, p, p + 1, bad, highs, cbad);
            if (f == 0) check(highs == h, "R6 eighth active time", highs, h);
            else        check(highs == h, "R5 sixteenth active time", highs, h);
            check(bad == 0, "R4/R7 period shape", bad, 0);
            check(cbad == 0, "R9 complement", cbad, 0);
        end

        // R8 mid-period change: pitch 1 loudness 8 (8 of 16), then loudness 2
        wr(2'b11, 16'h0000);
        @(negedge clk);
        wr(2'b11, 16'h0811);
        @(negedge clk);
        measure(8, 16, 4, bad, highs, cbad);
        wr(2'b10, 16'h0200);
        bad = 0;
        for (int i = 4; i < 16; i++) begin
            if (out_p != (i < 8)) bad++;
            pulse();
        end
        check(bad == 0, "R8 current period unchanged", bad, 0);
        measure(2, 16, 16, bad, highs, cbad);
        check(highs == 2 && bad == 0, "R8 next period uses new duty", highs, 2);

        // R10 polarity inversion while running, takes effect at once
        wr(2'b11, 16'h0000);
        @(negedge clk);
        wr(2'b11, 16'h0811);
        @(negedge clk);
        check(out_p == 1'b1 && out_n == 1'b0, "R10 pol0 active level", {out_p, out_n}, 2);
        wr(2'b10, 16'h1800);
        check(out_p == 1'b0 && out_n == 1'b1, "R10 pol1 inverted", {out_p, out_n}, 1);
        // R11 idle with polarity 1
        wr(2'b01, 16'h0010);
        @(negedge clk);
        check(out_p == 1'b1 && out_n == 1'b1, "R11 idle pins pol1", {out_p, out_n}, 3);
        // R11 idle ignores ticks, restart begins a fresh period
        pulse(); pulse(); pulse();
        wr(2'b11, 16'h0011);
        @(negedge clk);
        measure(1, 16, 16, bad, highs, cbad);
        check(bad == 0 && highs == 1, "R11 restart from zero", highs, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule